// File: doc/BRIEF.md
# Block-Paced Pseudo-DMA Transfer Engine

This engine moves data between a host register port and an 8-bit REQ/ACK data interface on a SCSI bus. A 128-byte staging buffer sits in the middle. The host owns one side and reaches it through a byte data port. A handshake sequencer owns the other side and exchanges one byte per REQ/ACK pair with the target. Data moves in blocks. A block holds 128 bytes, or fewer when the target has fewer bytes left to transfer. An 8-bit block counter sets how many blocks make up one transfer.

A direction bit, a not-ready flag and a loaded-count flag decide which side owns the buffer at any moment. For host-to-target transfers, the host fills a block and the engine then drains it onto the bus. For target-to-host transfers, the engine fills a block from the bus and the host then reads it out. When the last block completes, the engine raises an end-of-transfer flag. Outbound transfers also raise a last-byte-sent flag. If enabled, an interrupt is raised and stays set until it is acknowledged. If the target releases BSY while bus monitoring is on, the transfer stops.

Register offsets on `reg_addr`: 0 is control and status, 1 is the block count, 2 is the data port, and 3 is the mode register.

Top module: `pdma_xfer_engine`

## Requirements
- R1: After reset, the status register reads 0x84 (idle bit 7 set, not-ready bit 2 set). The block count reads 0. The mode register reads 0. `irq`, `eod`, `last_sent` and `scsi_ack` are all low.
- R2: A control write updates only bits 6:3. Bit 6 is the direction: 1 moves data from target to host, 0 moves data from host to target. In the status byte, bit 7 reads as 1 exactly when the engine is not busy. Bits 1:0 keep their value, which is 0.
- R3: Changing direction to target-to-host places the host pointer at the end of the block and sets not-ready. Changing it to host-to-target moves the pointer to 0 and clears not-ready. A block-count write loads the count and marks it loaded. It also applies this same repositioning for the current direction.
- R4: In host-to-target mode, each data-port write stores a byte and advances the pointer. The write that fills the block sets not-ready and busy. Data-port writes are ignored in target-to-host mode.
- R5: In target-to-host mode, data-port reads return the buffered bytes in order. The read of the last byte sets not-ready. A read past the end of the block, or in the wrong direction, returns 0xFF.
- R6: The bus side runs only when DMA mode (mode bit 0) is on, the count is loaded and not-ready is set. For each byte, the engine waits for REQ and raises ACK on the next cycle, with outbound data valid while ACK is high. It holds ACK until REQ drops. Bytes travel in buffer order.
- R7: When a block completes, not-ready clears, busy clears, the host pointer returns to 0 and the count decrements by one modulo 256.
- R8: When the count reaches zero, the loaded flag clears and `eod` is set. `last_sent` is set only for host-to-target transfers.
- R9: When mode bit 1 is set, completion of the final block raises `irq`. `irq` stays high until `irq_ack` is pulsed. It is never raised when mode bit 1 is clear.
- R10: With mode bit 2 set, an inactive `scsi_bsy` during DMA mode clears DMA mode and the loaded flag, and releases ACK. A later REQ gets no ACK until the count is reloaded.
- R11: The block length is the smaller of 128 and `tgt_len`.
- R12: A mode write that turns DMA mode from on to off clears `eod` and `last_sent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (advances the data port) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| tgt_len | input | 16 | Bytes the target has left to transfer |
| irq_ack | input | 1 | Clears the interrupt |
| scsi_req | input | 1 | Target REQ, active high |
| scsi_bsy | input | 1 | Target BSY, active high |
| scsi_din | input | 8 | Data from the target |
| scsi_dout | output | 8 | Data to the target |
| scsi_ack | output | 1 | Initiator ACK, active high |
| irq | output | 1 | Sticky end-of-transfer interrupt |
| eod | output | 1 | End of transfer reached |
| last_sent | output | 1 | Last byte sent (host-to-target transfer only) |

## Verification
Register writes and data-port strobes take effect at the clock edge that ends the strobe cycle. A status read in the next cycle already shows the new pointer, not-ready and busy state. ACK rises one cycle after REQ is seen high and falls one cycle after REQ is seen low. Block completion updates the count, `eod`, `last_sent` and `irq` at that same falling-ACK edge. The bench drives inputs and samples outputs at falling clock edges. It polls status bit 2 instead of assuming a fixed latency, because the target model spaces its REQs by random delays.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_COUNT = 2'd1,
    RA_DATA  = 2'd2,
    RA_MODE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_WREQ = 2'd1,
    BS_ACK  = 2'd2
  } bus_state_e;

  localparam int MODE_DMA  = 0;
  localparam int MODE_EOPI = 1;
  localparam int MODE_BMON = 2;
  localparam int CTRL_DIR  = 6;
endpackage

// File: rtl/pdma_stage_buf.sv
module pdma_stage_buf #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (row_en) mem[g] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pdma_bus_seq.sv
module pdma_bus_seq
  import pdma_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              dir_in,
  input  logic [PTR_W-1:0]  blk_len,
  input  logic              scsi_req,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] scsi_dout,
  output logic              scsi_ack,
  output logic              blk_done
);
  bus_state_e        state_q, state_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              ack_q;
  logic              last_byte;

  assign last_byte = (PTR_W'(ptr_q + 1'b1) == blk_len);
  assign buf_addr  = ptr_q[ADDR_W-1:0];

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    dout_d   = dout_q;
    buf_we   = 1'b0;
    blk_done = 1'b0;
    case (state_q)
      BS_IDLE: if (go) state_d = BS_WREQ;
      BS_WREQ: begin
        if (scsi_req) begin
          state_d = BS_ACK;
          if (dir_in) buf_we = 1'b1;
          else        dout_d = buf_rdata;
        end
      end
      BS_ACK: begin
        if (!scsi_req) begin
          if (last_byte) begin
            state_d  = BS_IDLE;
            ptr_d    = '0;
            blk_done = 1'b1;
          end else begin
            state_d = BS_WREQ;
            ptr_d   = PTR_W'(ptr_q + 1'b1);
          end
        end
      end
      default: state_d = BS_IDLE;
    endcase
    if (abort) begin
      state_d  = BS_IDLE;
      ptr_d    = '0;
      buf_we   = 1'b0;
      blk_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      ptr_q   <= '0;
      dout_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      dout_q  <= dout_d;
      ack_q   <= (state_d == BS_ACK);
    end
  end

  assign scsi_ack  = ack_q;
  assign scsi_dout = dout_q;

  // ACK only follows a sampled REQ (R6)
  assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scsi_ack) |-> $past(scsi_req));
  // ACK held while REQ is still high (R6)
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_ack && scsi_req && !abort) |=> scsi_ack);
  // outbound data steady while ACK is up (R6)
  assert_dout_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_ack && $past(scsi_ack)) |-> $stable(scsi_dout));
  // abort drops ACK on the next cycle (R10)
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !scsi_ack);
endmodule

// File: rtl/pdma_host_if.sv
module pdma_host_if
  import pdma_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PTR_W-1:0]  blk_len,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              hbuf_we,
  output logic [ADDR_W-1:0] hbuf_addr,
  input  logic              blk_done,
  input  logic              scsi_bsy,
  input  logic              irq_ack,
  output logic              dir_out,
  output logic              go,
  output logic              abort,
  output logic              irq,
  output logic              eod,
  output logic              last_sent
);
  logic [3:0]        ctrl_q, ctrl_d;
  logic              nr_q, nr_d;
  logic              busy_q, busy_d;
  logic [PTR_W-1:0]  hptr_q, hptr_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              loaded_q, loaded_d;
  logic              dma_q, dma_d, eopi_q, eopi_d, bmon_q, bmon_d;
  logic              eod_q, eod_d, last_q, last_d, irq_q, irq_d;
  logic              wr_ctrl, wr_cnt, wr_mode, wr_data, rd_data;
  logic              dir_q, in_blk, host_last;

  assign dir_q     = ctrl_q[CTRL_DIR-3];
  assign in_blk    = (hptr_q < blk_len);
  assign host_last = (PTR_W'(hptr_q + 1'b1) == blk_len);
  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_cnt    = reg_wr && (reg_addr == RA_COUNT);
  assign wr_mode   = reg_wr && (reg_addr == RA_MODE);
  assign wr_data   = reg_wr && (reg_addr == RA_DATA);
  assign rd_data   = reg_rd && (reg_addr == RA_DATA);
  assign abort     = bmon_q && !scsi_bsy && dma_q;
  assign go        = dma_q && loaded_q && nr_q && (blk_len != '0);
  assign hbuf_addr = hptr_q[ADDR_W-1:0];

  always_comb begin
    ctrl_d = ctrl_q;  nr_d = nr_q;  busy_d = busy_q;  hptr_d = hptr_q;
    cnt_d = cnt_q;  loaded_d = loaded_q;  dma_d = dma_q;  eopi_d = eopi_q;
    bmon_d = bmon_q;  eod_d = eod_q;  last_d = last_q;  irq_d = irq_q;
    hbuf_we = 1'b0;
    if (irq_ack) irq_d = 1'b0;
    if (wr_ctrl) begin
      ctrl_d = reg_wdata[6:3];
      if (reg_wdata[CTRL_DIR] && !dir_q) begin
        hptr_d = blk_len;  nr_d = 1'b1;
      end else if (!reg_wdata[CTRL_DIR] && dir_q) begin
        hptr_d = '0;  nr_d = 1'b0;
      end
    end
    if (wr_cnt) begin
      cnt_d    = reg_wdata;
      loaded_d = 1'b1;
      if (dir_q) begin hptr_d = blk_len; nr_d = 1'b1; end
      else       begin hptr_d = '0;      nr_d = 1'b0; end
    end
    if (wr_mode) begin
      dma_d  = reg_wdata[MODE_DMA];
      eopi_d = reg_wdata[MODE_EOPI];
      bmon_d = reg_wdata[MODE_BMON];
      if (dma_q && !reg_wdata[MODE_DMA]) begin
        eod_d = 1'b0;  last_d = 1'b0;
      end
    end
    if (wr_data && !dir_q && in_blk) begin
      hbuf_we = 1'b1;
      hptr_d  = PTR_W'(hptr_q + 1'b1);
      if (host_last) begin nr_d = 1'b1; busy_d = 1'b1; end
    end
    if (rd_data && dir_q && in_blk) begin
      hptr_d = PTR_W'(hptr_q + 1'b1);
      if (host_last) nr_d = 1'b1;
    end
    if (blk_done) begin
      nr_d   = 1'b0;
      busy_d = 1'b0;
      hptr_d = '0;
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == DATA_W'(1)) begin
        loaded_d = 1'b0;
        eod_d    = 1'b1;
        last_d   = !dir_q;
        if (eopi_q) irq_d = 1'b1;
      end
    end
    if (abort) begin
      dma_d    = 1'b0;
      loaded_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;  nr_q <= 1'b1;  busy_q <= 1'b0;  hptr_q <= PTR_W'(DEPTH);
      cnt_q <= '0;  loaded_q <= 1'b0;  dma_q <= 1'b0;  eopi_q <= 1'b0;
      bmon_q <= 1'b0;  eod_q <= 1'b0;  last_q <= 1'b0;  irq_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;  nr_q <= nr_d;  busy_q <= busy_d;  hptr_q <= hptr_d;
      cnt_q <= cnt_d;  loaded_q <= loaded_d;  dma_q <= dma_d;  eopi_q <= eopi_d;
      bmon_q <= bmon_d;  eod_q <= eod_d;  last_q <= last_d;  irq_q <= irq_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {!busy_q, ctrl_q, nr_q, 2'b00};
      RA_COUNT: reg_rdata = cnt_q;
      RA_DATA:  reg_rdata = (dir_q && in_blk) ? buf_rdata : '1;
      default:  reg_rdata = DATA_W'({bmon_q, eopi_q, dma_q});
    endcase
  end

  assign dir_out   = dir_q;
  assign irq       = irq_q;
  assign eod       = eod_q;
  assign last_sent = last_q;

  // interrupt stays until acknowledged (R9)
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // a finished block decrements the count by one (R7)
  assert_count_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !wr_cnt) |=> (cnt_q == DATA_W'($past(cnt_q) - 1'b1)));
  // busy is only released by a finished block (R7)
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(blk_done));
  // end of transfer only once the count is exhausted (R8)
  assert_eod_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eod) |-> (cnt_q == '0));
  // after a bus-free abort the bus side is not started (R10)
  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> !go);
endmodule

// File: rtl/pdma_xfer_engine.sv
module pdma_xfer_engine
  import pdma_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LEN_W-1:0]  tgt_len,
  input  logic              irq_ack,
  input  logic              scsi_req,
  input  logic              scsi_bsy,
  input  logic [DATA_W-1:0] scsi_din,
  output logic [DATA_W-1:0] scsi_dout,
  output logic              scsi_ack,
  output logic              irq,
  output logic              eod,
  output logic              last_sent
);
  localparam int PTR_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  blk_len;
  logic              dir, go, abort, blk_done;
  logic              hbuf_we, bbuf_we, mem_we;
  logic [ADDR_W-1:0] hbuf_addr, bbuf_addr, mem_waddr;
  logic [DATA_W-1:0] mem_wdata, host_rd, bus_rd;

  assign blk_len = (tgt_len >= LEN_W'(DEPTH)) ? PTR_W'(DEPTH) : PTR_W'(tgt_len);

  assign mem_we    = dir ? bbuf_we : hbuf_we;
  assign mem_waddr = dir ? bbuf_addr : hbuf_addr;
  assign mem_wdata = dir ? scsi_din : reg_wdata;

  pdma_stage_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(hbuf_addr), .rdata_a(host_rd),
    .raddr_b(bbuf_addr), .rdata_b(bus_rd)
  );

  pdma_host_if #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .blk_len(blk_len), .buf_rdata(host_rd), .hbuf_we(hbuf_we),
    .hbuf_addr(hbuf_addr), .blk_done(blk_done), .scsi_bsy(scsi_bsy),
    .irq_ack(irq_ack), .dir_out(dir), .go(go), .abort(abort),
    .irq(irq), .eod(eod), .last_sent(last_sent)
  );

  pdma_bus_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .dir_in(dir),
    .blk_len(blk_len), .scsi_req(scsi_req), .buf_rdata(bus_rd),
    .buf_we(bbuf_we), .buf_addr(bbuf_addr), .scsi_dout(scsi_dout),
    .scsi_ack(scsi_ack), .blk_done(blk_done)
  );

  // eod and last_sent never rise without a completed block (R8)
  assert_eod_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eod) |-> $past(blk_done));
endmodule

// File: tb/tb_pdma_xfer_engine.sv
`timescale 1ns/1ps
module tb_pdma_xfer_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [15:0] tgt_len = 16'd128;
  logic       irq_ack = 1'b0;
  logic       scsi_req = 1'b0, scsi_bsy = 1'b1;
  logic [7:0] scsi_din = 8'd0;
  logic [7:0] scsi_dout;
  logic       scsi_ack, irq, eod, last_sent;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] tx [256];
  logic [7:0] rx [256];
  int rxn = 0;

  always #2.5 clk = ~clk;

  pdma_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tgt_len(tgt_len), .irq_ack(irq_ack), .scsi_req(scsi_req),
    .scsi_bsy(scsi_bsy), .scsi_din(scsi_din), .scsi_dout(scsi_dout),
    .scsi_ack(scsi_ack), .irq(irq), .eod(eod), .last_sent(last_sent)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input bit busy, input logic [3:0] ctl, input bit nr);
    return {!busy, ctl, nr, 2'b00};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] s;
    int n = 0;
    s = 8'h04;
    while (s[2] && n < 5000) begin
      peek(2'd0, s);
      n++;
    end
    chk({tag, " block not completed"}, int'(s[2]), 0);
  endtask

  // behavioural target: random REQ spacing, full interlocked handshake
  task automatic tgt_serve(input int n, input bit send, input int base);
    for (int i = 0; i < n; i++) begin
      int g;
      repeat ($urandom_range(0, 4)) @(negedge clk);
      if (send) scsi_din = tx[base + i];
      scsi_req = 1'b1;
      g = 0;
      do begin @(negedge clk); g++; end while (!scsi_ack && g < 3000);
      if (!send) begin rx[rxn] = scsi_dout; rxn++; end
      scsi_req = 1'b0;
      g = 0;
      do begin @(negedge clk); g++; end while (scsi_ack && g < 3000);
    end
  endtask

  task automatic fill_block(input int base);
    for (int i = 0; i < 128; i++) reg_write(2'd2, tx[base + i]);
  endtask

  task automatic h2t_host;
    logic [7:0] d;
    reg_write(2'd3, 8'h03);
    wait_ready("R7 h2t blk1");
    peek(2'd1, d); chk("R7 count after block 1", d, 1);
    peek(2'd0, d); chk("R7 status after block 1", d, status_exp(0, 4'h0, 0));
    chk("R9 no irq before last block", irq, 0);
    fill_block(128);
    wait_ready("R7 h2t blk2");
    peek(2'd1, d); chk("R7 count after block 2", d, 0);
    chk("R8 eod h2t", eod, 1);
    chk("R8 last_sent h2t", last_sent, 1);
    chk("R9 irq at end", irq, 1);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    int mism, ackseen;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 status after reset", d, 8'h84);
    peek(2'd1, d); chk("R1 count after reset", d, 0);
    peek(2'd3, d); chk("R1 mode after reset", d, 0);
    chk("R1 irq/eod/last/ack low", {irq, eod, last_sent, scsi_ack}, 0);

    // R2/R3 control field and direction repositioning
    reg_write(2'd0, 8'hFF);
    peek(2'd0, d); chk("R2 only bits 6:3 written, dir=1 sets not-ready", d, 8'hFC);
    reg_read(2'd2, d); chk("R5 read at end of block gives FF", d, 8'hFF);
    reg_write(2'd0, 8'h00);
    peek(2'd0, d); chk("R3 switch to h2t clears not-ready", d, 8'h80);

    // h2t transfer, 2 blocks of 128 (R11 clamp 200 -> 128)
    tgt_len = 16'd200;
    for (int i = 0; i < 256; i++) tx[i] = 8'($urandom);
    reg_write(2'd1, 8'd2);
    peek(2'd0, d); chk("R3 count load in h2t keeps ready", d, 8'h80);
    for (int i = 0; i < 127; i++) reg_write(2'd2, tx[i]);
    peek(2'd0, d); chk("R4 not full after 127 writes", d, 8'h80);
    reg_write(2'd2, tx[127]);
    peek(2'd0, d); chk("R4 full block sets busy and not-ready", d, 8'h04);
    // R6 no handshake while DMA mode is off
    scsi_req = 1'b1; ackseen = 0;
    repeat (20) begin @(negedge clk); ackseen |= int'(scsi_ack); end
    scsi_req = 1'b0;
    chk("R6 no ACK with DMA mode off", ackseen, 0);
    rxn = 0;
    fork
      tgt_serve(256, 1'b0, 0);
      h2t_host();
    join
    mism = 0;
    for (int i = 0; i < 256; i++) if (rx[i] !== tx[i]) mism++;
    chk("R6 bytes sent in buffer order", mism, 0);
    chk("R6 bytes sent count", rxn, 256);
    repeat (5) @(negedge clk);
    chk("R9 irq held until ack", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R9 irq cleared by ack", irq, 0);
    reg_write(2'd3, 8'h00);
    chk("R12 DMA off clears eod/last_sent", {eod, last_sent}, 0);

    // t2h transfer, 2 blocks of 40 bytes (R11), irq disabled
    tgt_len = 16'd40;
    for (int i = 0; i < 80; i++) tx[i] = 8'($urandom);
    reg_write(2'd0, 8'h40);
    peek(2'd0, d); chk("R3 switch to t2h sets not-ready", d, 8'hC4);
    reg_write(2'd3, 8'h01);
    reg_write(2'd1, 8'd2);
    fork
      tgt_serve(80, 1'b1, 0);
      begin
        for (int b = 0; b < 2; b++) begin
          wait_ready("R7 t2h block");
          if (b == 0) reg_write(2'd2, 8'h5A);
          mism = 0;
          for (int i = 0; i < 40; i++) begin
            reg_read(2'd2, d);
            if (d !== tx[b*40 + i]) mism++;
            if (i == 38) begin
              peek(2'd0, d); chk("R5 not-ready clear before last read", int'(d[2]), 0);
            end
          end
          chk(b == 0 ? "R4 write ignored in t2h, R5 read order" : "R5 read order blk2", mism, 0);
          peek(2'd0, d); chk("R5 last read sets not-ready", int'(d[2]), 1);
          if (b == 1) begin
            reg_read(2'd2, d); chk("R5 read past block end gives FF (R11 length 40)", d, 8'hFF);
          end
        end
      end
    join
    chk("R8 eod t2h", eod, 1);
    chk("R8 last_sent only for h2t", last_sent, 0);
    chk("R9 no irq when disabled", irq, 0);
    peek(2'd1, d); chk("R8 count zero", d, 0);

    // R10 abort on bus free
    reg_write(2'd3, 8'h00);
    reg_write(2'd0, 8'h00);
    tgt_len = 16'd128;
    for (int i = 0; i < 128; i++) tx[i] = 8'($urandom);
    reg_write(2'd1, 8'd1);
    fill_block(0);
    reg_write(2'd3, 8'h05);
    rxn = 0;
    tgt_serve(10, 1'b0, 0);
    chk("R6 partial bytes", rxn, 10);
    @(negedge clk); scsi_bsy = 1'b0;
    @(negedge clk);
    chk("R10 ACK released on abort", scsi_ack, 0);
    peek(2'd3, d); chk("R10 DMA mode cleared", int'(d[0]), 0);
    scsi_bsy = 1'b1;
    reg_write(2'd3, 8'h01);
    scsi_req = 1'b1; ackseen = 0;
    repeat (20) begin @(negedge clk); ackseen |= int'(scsi_ack); end
    scsi_req = 1'b0;
    chk("R10 no ACK after abort until reload", ackseen, 0);
    peek(2'd1, d); chk("R10 count kept", d, 1);
    chk("R10 no eod after abort", eod, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule